// File: doc/BRIEF.md
# Shared Bus Width and Lane Steering Front End

This block is the bus front end of a two-die memory package in which a flash die and an SRAM die share one address bus, one 16-bit data bus, and common output-enable and write-enable strobes. Each clock edge it samples the strobes and chip enables and picks one die, or none. It then steers the data pins for that die according to the die's own width mode.

The flash die and the SRAM die each have a word/byte setting that is independent of the other. In flash byte mode the top data pin is not a data pin: it is the least significant address bit. In SRAM byte mode a dedicated extra address input picks the byte. In SRAM word mode two lane controls open the upper and lower halves of the bus separately. For every data pin the block produces an output value and a per-pin drive enable.

Both memory arrays are small register-file models that are cleared by reset. A flash write is stored directly, with no command sequencing. Selecting both dies at once raises a clash flag, and neither die then drives the bus or stores anything.

The controller is a state machine with six states:

- `ST_IDLE`: nothing is driven.
- `ST_FL_READ`: flash read.
- `ST_FL_WRITE`: flash write.
- `ST_SR_READ`: SRAM read.
- `ST_SR_WRITE`: SRAM write.
- `ST_CLASH`: both dies selected.

Every state can move to every other state. The next state is decided afresh each edge, with this priority:

1. Both dies selected → `ST_CLASH`.
2. Only one die selected and write-enable low → that die's write state.
3. Only one die selected, write-enable high and output-enable low → that die's read state.
4. Any other case, including no die selected → `ST_IDLE`.

Top module: `mcp_bus_front`

## Requirements
- R1: While reset is low, and in the first cycle after it, no pin is driven, `dq_out` is zero and the clash flag is low. Reset clears both arrays to zero.
- R2: The SRAM is selected only when `sr_ce1_n` is 0 and `sr_ce2` is 1. The flash is selected when `fl_ce_n` is 0.
- R3: When both dies are selected, `sel_conflict` is 1 one cycle later. In that cycle no pin is driven, and neither array changes.
- R4: No pin is driven one cycle after any of these: no die is selected, output-enable is high, or write-enable is low.
- R5: A flash read in word mode (`fl_word`=1) drives all 16 pins with the stored word.
- R6: A flash read in byte mode (`fl_word`=0) drives only pins 7..0. Pins 15..8 are released. The value on `dq_in[15]` is the byte address: 0 selects bits 7..0 of the stored word and 1 selects bits 15..8.
- R7: An SRAM read in word mode (`sr_word`=1) drives pins 7..0 only when `lb_n` is 0 and pins 15..8 only when `ub_n` is 0.
- R8: An SRAM write in word mode stores bits 7..0 only when `lb_n` is 0 and bits 15..8 only when `ub_n` is 0. A disabled lane keeps its old contents.
- R9: In SRAM byte mode (`sr_word`=0), `sr_byte_hi` picks the byte: 1 selects bits 15..8 and 0 selects bits 7..0. Data travels on pins 7..0 only, and `lb_n` and `ub_n` have no effect.
- R10: A flash write in word mode stores all of `dq_in`. In byte mode it stores `dq_in[7:0]` into the byte that `dq_in[15]` selects, and leaves the other byte unchanged.
- R11: On every pin whose drive enable is 0, `dq_out` is 0.
- R12: Each die applies its own width mode. The setting of the other die's mode input has no effect on the selected die.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fl_ce_n | input | 1 | Flash chip enable, active low |
| sr_ce1_n | input | 1 | SRAM first enable, active low |
| sr_ce2 | input | 1 | SRAM second enable, active high |
| oe_n | input | 1 | Shared output enable, active low |
| we_n | input | 1 | Shared write enable, active low |
| fl_word | input | 1 | Flash width mode: 1 = word, 0 = byte |
| sr_word | input | 1 | SRAM width mode: 1 = word, 0 = byte |
| lb_n | input | 1 | SRAM lower-lane enable, active low |
| ub_n | input | 1 | SRAM upper-lane enable, active low |
| sr_byte_hi | input | 1 | SRAM byte address used in byte mode |
| addr | input | ADDR_W | Shared word address |
| dq_in | input | DATA_W | Value present on the data pins |
| dq_out | output | DATA_W | Value driven onto the data pins |
| dq_oe | output | DATA_W | Per-pin drive enable |
| sel_conflict | output | 1 | Both dies selected in the previous cycle |

## Verification
Every pin value, every drive enable and the clash flag are due in the cycle after the edge that samples the stimulus. They hold until the next edge. A write lands in its array on the edge after it is sampled, which is the same edge that samples an immediately following read. That read therefore returns the new data. The bench drives on the falling edge and pushes one expected item per driven cycle. Its monitor pops and compares one item shortly after each rising edge, so every comparison falls exactly one edge after its stimulus.

// File: rtl/mcp_bus_pkg.sv
package mcp_bus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_FL_READ  = 3'd1,
        ST_FL_WRITE = 3'd2,
        ST_SR_READ  = 3'd3,
        ST_SR_WRITE = 3'd4,
        ST_CLASH    = 3'd5
    } bus_state_e;

    // Per-access settings captured together with the state.
    typedef struct packed {
        logic fl_word;
        logic sr_word;
        logic lb_n;
        logic ub_n;
        logic fl_lsb;
        logic sr_lsb;
    } lane_cfg_t;

endpackage

// File: rtl/mcp_sel_decode.sv
module mcp_sel_decode
    import mcp_bus_pkg::*;
(
    input  logic       fl_ce_n,
    input  logic       sr_ce1_n,
    input  logic       sr_ce2,
    input  logic       oe_n,
    input  logic       we_n,
    output bus_state_e nxt_state
);
    logic fl_sel;
    logic sr_sel;

    assign fl_sel = ~fl_ce_n;
    assign sr_sel = ~sr_ce1_n & sr_ce2;

    always_comb begin
        nxt_state = ST_IDLE;
        unique case ({fl_sel, sr_sel})
            2'b11: nxt_state = ST_CLASH;
            2'b10: begin
                if (!we_n)      nxt_state = ST_FL_WRITE;
                else if (!oe_n) nxt_state = ST_FL_READ;
                else            nxt_state = ST_IDLE;
            end
            2'b01: begin
                if (!we_n)      nxt_state = ST_SR_WRITE;
                else if (!oe_n) nxt_state = ST_SR_READ;
                else            nxt_state = ST_IDLE;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/mcp_word_store.sv
module mcp_word_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_be,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = DATA_W / 2;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            for (int l = 0; l < 2; l++) begin
                if (wr_be[l]) mem[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/mcp_lane_steer.sv
module mcp_lane_steer
    import mcp_bus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  bus_state_e        state,
    input  lane_cfg_t         cfg,
    input  logic [DATA_W-1:0] wcap,
    input  logic [DATA_W-1:0] fl_rd,
    input  logic [DATA_W-1:0] sr_rd,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] dq_oe,
    output logic              clash,
    output logic [1:0]        die_we,
    output logic [1:0]        fl_be,
    output logic [1:0]        sr_be,
    output logic [DATA_W-1:0] wdata
);
    localparam int LANE_W = DATA_W / 2;

    logic [DATA_W-1:0] lane_mask;
    assign lane_mask = {{LANE_W{~cfg.ub_n}}, {LANE_W{~cfg.lb_n}}};

    always_comb begin
        dq_out = '0;
        dq_oe  = '0;
        clash  = 1'b0;
        die_we = 2'b00;
        fl_be  = 2'b00;
        sr_be  = 2'b00;
        wdata  = wcap;
        unique case (state)
            ST_IDLE: begin
                dq_oe = '0;
            end
            ST_CLASH: begin
                clash = 1'b1;
            end
            ST_FL_READ: begin
                if (cfg.fl_word) begin
                    dq_out = fl_rd;
                    dq_oe  = '1;
                end else begin
                    dq_out[LANE_W-1:0] = cfg.fl_lsb ? fl_rd[DATA_W-1:LANE_W] : fl_rd[LANE_W-1:0];
                    dq_oe[LANE_W-1:0]  = '1;
                end
            end
            ST_FL_WRITE: begin
                die_we[0] = 1'b1;
                if (cfg.fl_word) begin
                    fl_be = 2'b11;
                end else begin
                    fl_be = cfg.fl_lsb ? 2'b10 : 2'b01;
                    wdata = {2{wcap[LANE_W-1:0]}};
                end
            end
            ST_SR_READ: begin
                if (cfg.sr_word) begin
                    dq_oe  = lane_mask;
                    dq_out = sr_rd & lane_mask;
                end else begin
                    dq_out[LANE_W-1:0] = cfg.sr_lsb ? sr_rd[DATA_W-1:LANE_W] : sr_rd[LANE_W-1:0];
                    dq_oe[LANE_W-1:0]  = '1;
                end
            end
            ST_SR_WRITE: begin
                die_we[1] = 1'b1;
                if (cfg.sr_word) begin
                    sr_be = {~cfg.ub_n, ~cfg.lb_n};
                end else begin
                    sr_be = cfg.sr_lsb ? 2'b10 : 2'b01;
                    wdata = {2{wcap[LANE_W-1:0]}};
                end
            end
            default: begin
                dq_oe = '0;
            end
        endcase
    end
endmodule

// File: rtl/mcp_bus_front.sv
module mcp_bus_front
    import mcp_bus_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fl_ce_n,
    input  logic              sr_ce1_n,
    input  logic              sr_ce2,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              fl_word,
    input  logic              sr_word,
    input  logic              lb_n,
    input  logic              ub_n,
    input  logic              sr_byte_hi,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] dq_oe,
    output logic              sel_conflict
);
    localparam int NUM_DIE = 2;

    bus_state_e        state_q;
    bus_state_e        state_d;
    lane_cfg_t         cfg_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wcap_q;

    logic [NUM_DIE-1:0] die_we;
    logic [1:0]         fl_be;
    logic [1:0]         sr_be;
    logic [DATA_W-1:0]  wdata;
    logic [DATA_W-1:0]  rd_bus [NUM_DIE];
    logic [1:0]         be_bus [NUM_DIE];

    mcp_sel_decode u_dec (
        .fl_ce_n   (fl_ce_n),
        .sr_ce1_n  (sr_ce1_n),
        .sr_ce2    (sr_ce2),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .nxt_state (state_d)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Access capture register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            addr_q <= '0;
            wcap_q <= '0;
        end else begin
            cfg_q.fl_word <= fl_word;
            cfg_q.sr_word <= sr_word;
            cfg_q.lb_n    <= lb_n;
            cfg_q.ub_n    <= ub_n;
            cfg_q.fl_lsb  <= dq_in[DATA_W-1];
            cfg_q.sr_lsb  <= sr_byte_hi;
            addr_q        <= addr;
            wcap_q        <= dq_in;
        end
    end

    assign be_bus[0] = fl_be;
    assign be_bus[1] = sr_be;

    for (genvar d = 0; d < NUM_DIE; d++) begin : g_die
        mcp_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (die_we[d]),
            .wr_be   (be_bus[d]),
            .wr_addr (addr_q),
            .wr_data (wdata),
            .rd_addr (addr_q),
            .rd_data (rd_bus[d])
        );
    end

    mcp_lane_steer #(.DATA_W(DATA_W)) u_steer (
        .state  (state_q),
        .cfg    (cfg_q),
        .wcap   (wcap_q),
        .fl_rd  (rd_bus[0]),
        .sr_rd  (rd_bus[1]),
        .dq_out (dq_out),
        .dq_oe  (dq_oe),
        .clash  (sel_conflict),
        .die_we (die_we),
        .fl_be  (fl_be),
        .sr_be  (sr_be),
        .wdata  (wdata)
    );
endmodule

// File: rtl/mcp_bus_front_chk.sv
module mcp_bus_front_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fl_ce_n,
    input logic              sr_ce1_n,
    input logic              sr_ce2,
    input logic              oe_n,
    input logic              we_n,
    input logic              fl_word,
    input logic              sr_word,
    input logic              lb_n,
    input logic              ub_n,
    input logic [DATA_W-1:0] dq_out,
    input logic [DATA_W-1:0] dq_oe,
    input logic              sel_conflict
);
    localparam int LANE_W = DATA_W / 2;

    logic fl_sel;
    logic sr_sel;
    assign fl_sel = ~fl_ce_n;
    assign sr_sel = ~sr_ce1_n & sr_ce2;

    // R3
    clash_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_sel && sr_sel) |=> sel_conflict);

    // R3
    clash_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_conflict |-> (dq_oe == '0));

    // R4
    oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> (dq_oe == '0));

    // R4
    no_die_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_sel && !sr_sel) |=> (dq_oe == '0 && !sel_conflict));

    // R6
    fl_byte_hi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_sel && !sr_sel && !fl_word) |=> (dq_oe[DATA_W-1:LANE_W] == '0));

    // R7
    sr_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_sel && !fl_sel && !oe_n && we_n && sr_word)
        |=> (dq_oe == {{LANE_W{~$past(ub_n)}}, {LANE_W{~$past(lb_n)}}}));

    // R11
    undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((dq_out & ~dq_oe) == '0));
endmodule

bind mcp_bus_front mcp_bus_front_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fl_ce_n      (fl_ce_n),
    .sr_ce1_n     (sr_ce1_n),
    .sr_ce2       (sr_ce2),
    .oe_n         (oe_n),
    .we_n         (we_n),
    .fl_word      (fl_word),
    .sr_word      (sr_word),
    .lb_n         (lb_n),
    .ub_n         (ub_n),
    .dq_out       (dq_out),
    .dq_oe        (dq_oe),
    .sel_conflict (sel_conflict)
);

// File: tb/mcp_bus_front_test.sv
module mcp_bus_front_test;
    localparam int AW = 4;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fl_ce_n = 1'b1, sr_ce1_n = 1'b1, sr_ce2 = 1'b0, oe_n = 1'b1, we_n = 1'b1;
    logic fl_word = 1'b1, sr_word = 1'b1, lb_n = 1'b1, ub_n = 1'b1, sr_byte_hi = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out, dq_oe;
    logic sel_conflict;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic [DW-1:0] dout;
        logic [DW-1:0] doe;
        logic          clash;
        string         req;
    } exp_t;
    exp_t q[$];

    logic [DW-1:0] fl_ref [16];
    logic [DW-1:0] sr_ref [16];

    always #4 clk = ~clk;

    mcp_bus_front #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .fl_ce_n(fl_ce_n), .sr_ce1_n(sr_ce1_n), .sr_ce2(sr_ce2),
        .oe_n(oe_n), .we_n(we_n), .fl_word(fl_word), .sr_word(sr_word), .lb_n(lb_n),
        .ub_n(ub_n), .sr_byte_hi(sr_byte_hi), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .sel_conflict(sel_conflict)
    );

    task automatic check(input string req, input logic [DW-1:0] got_o, input logic [DW-1:0] got_e,
                         input logic got_c, input exp_t e);
        checks++;
        if (got_o !== e.dout || got_e !== e.doe || got_c !== e.clash) begin
            errors++;
            $display("FAIL %s: got out=%h oe=%h clash=%b expected out=%h oe=%h clash=%b",
                     req, got_o, got_e, got_c, e.dout, e.doe, e.clash);
        end
    endtask

    // Driver: ctl = {fl_ce_n, sr_ce1_n, sr_ce2, oe_n, we_n, fl_word, sr_word, lb_n, ub_n}
    task automatic drive(input logic [8:0] ctl, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic hi);
        exp_t e;
        logic fs, ss, lsb;
        logic [DW-1:0] m;
        @(negedge clk);
        {fl_ce_n, sr_ce1_n, sr_ce2, oe_n, we_n, fl_word, sr_word, lb_n, ub_n} = ctl;
        addr = a; dq_in = d; sr_byte_hi = hi;
        e.dout = '0; e.doe = '0; e.clash = 1'b0; e.req = "R4 idle/disabled";
        fs = ~ctl[8];
        ss = ~ctl[7] & ctl[6];
        if (fs && ss) begin
            e.clash = 1'b1; e.req = "R3 dual select";
        end else if (fs) begin
            lsb = d[15];
            if (!ctl[4]) begin
                e.req = "R10 flash write (outputs off)";
                if (ctl[3]) fl_ref[a] = d;
                else if (lsb) fl_ref[a][15:8] = d[7:0];
                else fl_ref[a][7:0] = d[7:0];
            end else if (!ctl[5]) begin
                if (ctl[3]) begin
                    e.req = "R5 flash word read"; e.dout = fl_ref[a]; e.doe = 16'hFFFF;
                end else begin
                    e.req = "R6 flash byte read"; e.doe = 16'h00FF;
                    e.dout = {8'h00, lsb ? fl_ref[a][15:8] : fl_ref[a][7:0]};
                end
            end
        end else if (ss) begin
            if (!ctl[4]) begin
                e.req = "R8/R9 sram write (outputs off)";
                if (ctl[2]) begin
                    if (!ctl[1]) sr_ref[a][7:0] = d[7:0];
                    if (!ctl[0]) sr_ref[a][15:8] = d[15:8];
                end else if (hi) sr_ref[a][15:8] = d[7:0];
                else sr_ref[a][7:0] = d[7:0];
            end else if (!ctl[5]) begin
                if (ctl[2]) begin
                    e.req = "R7 sram word lanes";
                    m = {{8{~ctl[0]}}, {8{~ctl[1]}}};
                    e.doe = m; e.dout = sr_ref[a] & m;
                end else begin
                    e.req = "R9 sram byte read"; e.doe = 16'h00FF;
                    e.dout = {8'h00, hi ? sr_ref[a][15:8] : sr_ref[a][7:0]};
                end
            end
        end
        q.push_back(e);
    endtask

    // Monitor: one expected item per driven cycle, compared after the next rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.req, dq_out, dq_oe, sel_conflict, e);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_t r;
        for (int i = 0; i < 16; i++) begin fl_ref[i] = '0; sr_ref[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        r.dout = '0; r.doe = '0; r.clash = 1'b0; r.req = "R1 reset";
        check("R1 reset", dq_out, dq_oe, sel_conflict, r);
        rst_n = 1'b1;
        // R1: arrays cleared (read before any write)
        drive(9'b0_10_0_1_1_1_1_1, 4'd3, 16'h0000, 1'b0);
        drive(9'b1_01_0_1_1_1_0_0, 4'd3, 16'h0000, 1'b0);
        // Preload both arrays with word writes
        for (int a = 0; a < 16; a++) begin
            drive(9'b0_10_1_0_1_1_1_1, 4'(a), 16'(32'hA500 + a * 32'h0111), 1'b0);
            drive(9'b1_01_1_0_1_1_0_0, 4'(a), 16'(32'h3C00 + a * 32'h0203), 1'b0);
        end
        // R5 / R6: flash word read then both byte halves via dq_in[15]
        drive(9'b0_10_0_1_1_1_1_1, 4'd5, 16'h0000, 1'b0);
        drive(9'b0_10_0_1_0_1_1_1, 4'd5, 16'h0000, 1'b0);
        drive(9'b0_10_0_1_0_1_1_1, 4'd5, 16'h8000, 1'b0);
        // R10: flash byte write to upper byte, then word read back
        drive(9'b0_10_1_0_0_1_1_1, 4'd6, 16'h80C7, 1'b0);
        drive(9'b0_10_0_1_1_1_1_1, 4'd6, 16'h0000, 1'b0);
        // R8: SRAM word write, upper lane only, then read both lanes
        drive(9'b1_01_1_0_1_1_1_0, 4'd7, 16'hBEEF, 1'b0);
        drive(9'b1_01_0_1_1_1_0_0, 4'd7, 16'h0000, 1'b0);
        // R9: SRAM byte write to upper byte with lanes disabled, read back both ways
        drive(9'b1_01_1_0_1_0_1_1, 4'd8, 16'h005A, 1'b1);
        drive(9'b1_01_0_1_1_0_1_1, 4'd8, 16'h0000, 1'b1);
        drive(9'b1_01_0_1_1_1_0_0, 4'd8, 16'h0000, 1'b0);
        // R3: clash with write strobe must not disturb arrays
        drive(9'b0_01_1_0_1_1_0_0, 4'd9, 16'hFFFF, 1'b0);
        drive(9'b0_10_0_1_1_1_1_1, 4'd9, 16'h0000, 1'b0);
        drive(9'b1_01_0_1_1_1_0_0, 4'd9, 16'h0000, 1'b0);
        // R2 / R12: exhaustive control and mode sweep against the model
        for (int c = 0; c < 512; c++) begin
            drive(c[8:0], 4'($urandom), 16'($urandom), 1'($urandom));
            drive(9'b1_10_1_1_1_1_1_1, 4'd0, 16'h0000, 1'b0);
        end
        // R11 and readback of every address in every mode
        for (int a = 0; a < 16; a++) begin
            drive(9'b0_10_0_1_0_1_1_1, 4'(a), 16'h8000, 1'b0);
            drive(9'b1_01_0_1_1_0_0_0, 4'(a), 16'h0000, 1'b1);
            drive(9'b1_01_0_1_1_1_1_0, 4'(a), 16'h0000, 1'b0);
        end
        drive(9'b1_10_1_1_1_1_1_1, 4'd0, 16'h0000, 1'b0);
        @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule